// File: doc/BRIEF.md
# Odd-Modulus Bit-Serial Halving Multiplier

This block computes P = A·B·2^-n mod M for n-bit operands and an odd n-bit modulus, processing one multiplier bit per clock. The accumulator starts at zero. Bits of A are taken from the least significant end. On each step the block adds B gated by the current bit of A. If that sum would be odd, it also adds M. The sum is then halved exactly. After n such steps one conditional subtraction of M gives a result below M.

No full-width comparison takes place inside the loop. Whether M is added depends only on the accumulator's bit 0, the current bit of A and bit 0 of B. The decision can therefore be formed before the wide adder settles. A caller that works in the residue domain puts operands into that domain and takes results out of it with further invocations of this block. The caller can also check the raw relation P·2^n ≡ A·B (mod M) directly.

A computation begins when start_i is sampled high while the block is idle. The block raises done_o for a single cycle and presents the result. The result stays on result_o until the next computation completes.

Top module: `halving_modmul`

## Requirements
- R1: For odd M and A, B < M, result_o satisfies (result_o · 2^WIDTH) mod M = (A · B) mod M.
- R2: For odd M and B < M, result_o is strictly less than M.
- R3: When start_i is sampled high at a rising edge while idle, done_o goes high after exactly WIDTH+1 further rising edges and stays high for one cycle only.
- R4: start_i and the operand inputs are ignored while a computation is in progress; they change neither the result nor the timing of done_o.
- R5: result_o keeps its value from one done_o pulse until the next one.
- R6: While rst_ni is low and after its release, done_o is 0 and result_o is 0 until the first computation completes.
- R7: A zero operand (A = 0 or B = 0) yields result 0. With M = 1 and A = B = 0, the result is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a computation when idle |
| a_i | input | WIDTH | Multiplier operand A, scanned LSB first |
| b_i | input | WIDTH | Multiplicand operand B |
| m_i | input | WIDTH | Odd modulus M |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| result_o | output | WIDTH | A·B·2^-WIDTH mod M |

## Verification
The operand sets cover several cases. Extreme moduli (1, 3, 0x8001 and the largest odd 16-bit value) with operands at M-1 exercise the accumulator's headroom and the final subtraction. Zero operands and unit operands separate a broken gating of B from a broken parity decision. About twenty pseudo-random operand sets then exercise the modular relation and the range bound in general. A second start request with different operands, issued in the middle of a run, shows whether the busy block accepts new inputs. Idle cycles between runs show whether the output holds its value.

// File: rtl/halving_pkg.sv
package halving_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIX  = 2'd2
  } phase_e;
endpackage

// File: rtl/halving_seq.sv
module halving_seq
  import halving_pkg::*;
#(
  parameter int unsigned STEPS = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   load_o
);
  localparam int unsigned CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign phase_o = phase_q;
  assign load_o  = (phase_q == PH_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_RUN;
          cnt_q   <= '0;
        end
        PH_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) phase_q <= PH_FIX;
        end
        PH_FIX:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN) |-> (cnt_q < CNT_W'(STEPS)));

  // R3
  fix_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FIX) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/halving_step.sv
module halving_step #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH+1:0] acc_i,
  input  logic             a_bit_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH+1:0] acc_o,
  output logic             sum_lsb_o
);
  localparam int unsigned ACC_W = WIDTH + 2;

  logic [WIDTH-1:0] pp;
  logic             add_m;
  logic [ACC_W-1:0] sum;

  for (genvar k = 0; k < WIDTH; k++) begin : g_pp
    assign pp[k] = b_i[k] & a_bit_i;
  end

  // parity of acc + pp decides the modulus add ahead of the wide adder
  assign add_m = acc_i[0] ^ (a_bit_i & b_i[0]);

  always_comb begin
    sum = acc_i + {2'b00, pp} + (add_m ? {2'b00, m_i} : '0);
  end

  assign acc_o     = {1'b0, sum[ACC_W-1:1]};
  assign sum_lsb_o = sum[0];
endmodule

// File: rtl/halving_fix.sv
module halving_fix #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH+1:0] acc_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int unsigned DIF_W = WIDTH + 3;

  logic [DIF_W-1:0] diff;
  logic             below;

  assign diff  = {1'b0, acc_i} - {3'b000, m_i};
  assign below = diff[DIF_W-1];
  assign res_o = below ? acc_i[WIDTH-1:0] : diff[WIDTH-1:0];
endmodule

// File: rtl/halving_modmul.sv
module halving_modmul
  import halving_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] m_i,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int unsigned ACC_W = WIDTH + 2;

  phase_e           phase;
  logic             load;
  logic [WIDTH-1:0] a_q, b_q, m_q, res_q;
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic             sum_lsb;
  logic [WIDTH-1:0] fixed;
  logic             done_q;

  halving_seq #(.STEPS(WIDTH)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .phase_o (phase),
    .load_o  (load)
  );

  halving_step #(.WIDTH(WIDTH)) i_step (
    .acc_i     (acc_q),
    .a_bit_i   (a_q[0]),
    .b_i       (b_q),
    .m_i       (m_q),
    .acc_o     (acc_nxt),
    .sum_lsb_o (sum_lsb)
  );

  halving_fix #(.WIDTH(WIDTH)) i_fix (
    .acc_i (acc_q),
    .m_i   (m_q),
    .res_o (fixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      m_q    <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        a_q   <= a_i;
        b_q   <= b_i;
        m_q   <= m_i;
        acc_q <= '0;
      end else if (phase == PH_RUN) begin
        acc_q <= acc_nxt;
        a_q   <= a_q >> 1;
      end else if (phase == PH_FIX) begin
        res_q  <= fixed;
        done_q <= 1'b1;
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;

  // R1
  even_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_RUN && m_q[0]) |-> !sum_lsb);

  // R2
  acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE && m_q[0] && b_q < m_q) |-> (acc_q < {1'b0, m_q, 1'b0}));

  // R2
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && m_q[0] && b_q < m_q) |-> (result_o < m_q));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE) |=> ($stable(m_q) && $stable(b_q)));

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_FIX) |=> $stable(result_o));
endmodule

// File: tb/test_halving_modmul.sv
module test_halving_modmul;
  localparam int unsigned N = 16;

  typedef struct {
    longint unsigned a;
    longint unsigned b;
    longint unsigned m;
    longint unsigned due;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] a_in = '0, b_in = '0, m_in = '0;
  logic         done;
  logic [N-1:0] result;

  int unsigned     errors = 0;
  int unsigned     checks = 0;
  longint unsigned cyc = 0;
  item_t           sb_q[$];
  int unsigned     issued = 0;
  int unsigned     seen = 0;
  logic            prev_done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  halving_modmul #(.WIDTH(N)) i_halving_modmul (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .a_i      (a_in),
    .b_i      (b_in),
    .m_i      (m_in),
    .done_o   (done),
    .result_o (result)
  );

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: issue one computation, optionally poke start mid-run
  task automatic drive(input longint unsigned a, input longint unsigned b,
                       input longint unsigned m, input bit poke);
    item_t it;
    @(negedge clk);
    a_in  = N'(a);
    b_in  = N'(b);
    m_in  = N'(m);
    start = 1'b1;
    it.a = a; it.b = b; it.m = m;
    it.due = cyc + N + 2;
    sb_q.push_back(it);
    issued++;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      // R4: a second request while busy must be ignored
      a_in  = N'(m - 1);
      b_in  = N'(m - 2);
      m_in  = N'(m + 2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      a_in  = '0; b_in = '0; m_in = '0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pop and compare on every done pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) check(1'b0, "R3 pulse width", 1, 0);
      if (done) begin
        seen++;
        if (sb_q.size() == 0) begin
          check(1'b0, "R4 unexpected done", seen, issued);
        end else begin
          item_t it;
          longint unsigned p, lhs, rhs;
          it  = sb_q.pop_front();
          p   = longint'(result);
          lhs = (p << N) % it.m;
          rhs = (it.a * it.b) % it.m;
          check(lhs == rhs, "R1 product relation", lhs, rhs);
          check(p < it.m, "R2 result below M", p, it.m);
          check(cyc == it.due, "R3 latency", cyc, it.due);
          if (it.a == 0 || it.b == 0) check(p == 0, "R7 zero operand", p, 0);
        end
      end
    end
    prev_done <= done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    longint unsigned x;
    logic [N-1:0]    held;
    x = 64'h1234_5678;

    // R6: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R6 done in reset", done, 0);
    check(result == '0, "R6 result in reset", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R6 done after release", done, 0);
    check(result == '0, "R6 result after release", result, 0);

    drive(0, 0, 1, 0);                    // R7 M = 1
    drive(0, 16'h1234, 16'hFFF1, 0);      // R7 A = 0
    drive(16'h4321, 0, 16'hFFF1, 0);      // R7 B = 0
    drive(1, 1, 3, 0);
    drive(2, 2, 3, 0);
    drive(16'hFFF0, 16'hFFF0, 16'hFFF1, 0);
    drive(16'h8000, 16'h8000, 16'h8001, 0);
    drive(16'hFFFE, 16'hFFFE, 16'hFFFF, 1); // R4 poke mid-run
    drive(1, 16'h0ABC, 16'hC001, 0);

    // R5: result holds across idle cycles
    held = result;
    repeat (10) @(negedge clk);
    check(result == held, "R5 result holds", result, held);

    for (int i = 0; i < 20; i++) begin
      longint unsigned m, a, b;
      x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
      m = ((x >> 20) & 64'hFFFF) | 64'h1;
      a = ((x >> 36) & 64'hFFFF) % m;
      b = ((x >> 48) & 64'hFFFF) % m;
      drive(a, b, m, (i % 5) == 0);
    end

    repeat (N + 6) @(negedge clk);
    check(sb_q.size() == 0, "R4 all results returned", sb_q.size(), 0);
    check(seen == issued, "R4 done count", seen, issued);
    finish_run();
  end
endmodule